// File: doc/BRIEF.md
# Scrolling Display Line Scan Counter

This block produces the row address that an LCD refresh engine uses to fetch one row of pixel memory per display line. The memory holds a graphic area of 64 rows plus one extra icon row. A six-bit start-line register, written by a command, is copied into a six-bit line counter at the beginning of every frame. The counter then steps once per line clock, so changing the start line scrolls the whole graphic area without rewriting memory.

The last line slot of every frame always addresses the icon row, whatever the scroll offset. Two duty pins set how many line slots a frame holds. The block also drives a frame-start marker, the index of the common line being driven, and an AC polarity bit that flips once per frame. A small decoder classifies a host-side page address as graphic, icon or unmapped.

Top module: `scroll_line_scan`

## Requirements
- R1: Synchronous active-high reset clears the start-line register, the line counter, the slot position and the polarity bit, so the outputs read row_addr=0, com_idx=0, frame_start=1, icon_slot=0 and ac_pol=0.
- R2: The start-line register takes start_val only in a cycle with start_wr=1. A write does not change the row of the frame in progress, and start_val without start_wr has no effect on any later frame.
- R3: On the line clock that ends a frame, the line counter is loaded from the start-line register, so the first slot of the next frame addresses row start-line.
- R4: On every other line clock the line counter advances by one, modulo 64 (63 is followed by 0).
- R5: duty_sel selects the number of line slots per frame: 2'b00 gives 33, 2'b01 gives 49, and 2'b10 or 2'b11 gives 65.
- R6: The last slot of each frame raises icon_slot and drives row_addr=64, independent of the start line.
- R7: frame_start is high exactly during the first slot of each frame (com_idx=0) and low in all other slots.
- R8: ac_pol inverts on each line clock that ends a frame and holds its value otherwise.
- R9: page_addr 0 to 7 raises page_gfx, page_addr 8 raises page_icon, and page_addr 9 to 15 raises neither.
- R10: While line_en is low, row_addr, com_idx, frame_start and ac_pol keep their values.
- R11: com_idx equals the slot position inside the frame, counting from 0 at frame start up to the slot count minus one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_wr | input | 1 | Write strobe for the start-line register |
| start_val | input | 6 | New start-line value |
| line_en | input | 1 | One-cycle line clock enable; each high cycle is one display line |
| duty_sel | input | 2 | Duty select (lines per frame) |
| page_addr | input | 4 | Host page address to classify |
| row_addr | output | 7 | Memory row to fetch for the current line; 64 is the icon row |
| frame_start | output | 1 | High in the first slot of a frame |
| icon_slot | output | 1 | High in the icon slot that closes a frame |
| com_idx | output | 7 | Slot position within the frame |
| ac_pol | output | 1 | AC polarity, flipped once per frame |
| page_gfx | output | 1 | page_addr selects a graphic page |
| page_icon | output | 1 | page_addr selects the icon page |

## Verification
The assertions assume that reset is applied before line_en is used and that duty_sel changes only when the scan sits in a slot inside the new frame length, or at frame start. The stimulus changes duty_sel only in those states, and it issues start-line writes only in cycles with line_en low. Under these conditions, the frame-length and icon-slot checks see whole frames of the selected duty.

// File: rtl/lcdscan_pkg.sv
package lcdscan_pkg;

    localparam int unsigned LINE_W_DEF = 6;
    localparam int unsigned PAGE_W_DEF = 4;
    localparam int unsigned LINES_PER_PAGE = 8;

    typedef enum logic [1:0] {
        DUTY_HALF  = 2'b00,
        DUTY_3Q    = 2'b01,
        DUTY_FULLA = 2'b10,
        DUTY_FULLB = 2'b11
    } duty_e;

    // index of the last slot (the icon slot) for a duty choice
    function automatic int unsigned duty_last(input logic [1:0] sel, input int unsigned rows);
        case (duty_e'(sel))
            DUTY_HALF: return rows / 2;
            DUTY_3Q:   return (rows * 3) / 4;
            default:   return rows;
        endcase
    endfunction

    typedef struct packed {
        logic       gfx;
        logic       icon;
    } page_cls_t;

endpackage

// File: rtl/scan_seq.sv
module scan_seq #(
    parameter int unsigned SLOT_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              line_en,
    input  logic [SLOT_W-1:0] last_idx,
    output logic [SLOT_W-1:0] slot,
    output logic              at_last,
    output logic              ac_pol
);

    assign at_last = (slot >= last_idx);

    always_ff @(posedge clk) begin
        if (rst) begin
            slot   <= '0;
            ac_pol <= 1'b0;
        end else if (line_en) begin
            if (at_last) begin
                slot   <= '0;
                ac_pol <= ~ac_pol;
            end else begin
                slot   <= slot + 1'b1;
            end
        end
    end

    // R8: polarity flips on every frame end
    p_pol_flip_r8: assert property (@(posedge clk) disable iff (rst)
        (line_en && at_last) |=> (ac_pol != $past(ac_pol)));
    // R8, R10: polarity held otherwise
    p_pol_hold_r8: assert property (@(posedge clk) disable iff (rst)
        !(line_en && at_last) |=> $stable(ac_pol));
    // R10: no slot movement without a line clock
    p_slot_hold_r10: assert property (@(posedge clk) disable iff (rst)
        !line_en |=> $stable(slot));

endmodule

// File: rtl/line_ctr.sv
module line_ctr #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         wr,
    input  logic [W-1:0] wr_val,
    input  logic         line_en,
    input  logic         reload,
    output logic [W-1:0] cnt,
    output logic [W-1:0] start_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            start_q <= '0;
        end else if (wr) begin
            start_q <= wr_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (line_en) begin
            cnt <= reload ? start_q : cnt + 1'b1;
        end
    end

    // R2: register holds without a write
    p_start_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !wr |=> $stable(start_q));
    // R3: frame end copies start line
    p_reload_r3: assert property (@(posedge clk) disable iff (rst)
        (line_en && reload) |=> (cnt == $past(start_q)));
    // R4: modulo step
    p_step_r4: assert property (@(posedge clk) disable iff (rst)
        (line_en && !reload) |=> (cnt == W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/page_decode.sv
module page_decode
    import lcdscan_pkg::*;
#(
    parameter int unsigned PAGE_W    = 4,
    parameter int unsigned GFX_PAGES = 8
) (
    input  logic [PAGE_W-1:0] page,
    output page_cls_t         cls
);

    always_comb begin
        cls.gfx  = (32'(page) <  GFX_PAGES);
        cls.icon = (32'(page) == GFX_PAGES);
    end

    // R9: a page is never both graphic and icon
    always_comb begin
        a_page_excl_r9: assert ($onehot0({cls.gfx, cls.icon}));
    end

endmodule

// File: rtl/scroll_line_scan.sv
module scroll_line_scan
    import lcdscan_pkg::*;
#(
    parameter int unsigned LINE_W = LINE_W_DEF,
    parameter int unsigned PAGE_W = PAGE_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_wr,
    input  logic [LINE_W-1:0] start_val,
    input  logic              line_en,
    input  logic [1:0]        duty_sel,
    input  logic [PAGE_W-1:0] page_addr,
    output logic [LINE_W:0]   row_addr,
    output logic              frame_start,
    output logic              icon_slot,
    output logic [LINE_W:0]   com_idx,
    output logic              ac_pol,
    output logic              page_gfx,
    output logic              page_icon
);

    localparam int unsigned ROWS      = 2 ** LINE_W;
    localparam int unsigned SLOT_W    = LINE_W + 1;
    localparam int unsigned GFX_PAGES = ROWS / LINES_PER_PAGE;
    localparam logic [SLOT_W-1:0] ICON_ROW = SLOT_W'(ROWS);

    logic [SLOT_W-1:0] last_idx;
    logic [SLOT_W-1:0] slot;
    logic              at_last;
    logic [LINE_W-1:0] cnt;
    logic [LINE_W-1:0] start_q;
    page_cls_t         pcls;

    assign last_idx = SLOT_W'(duty_last(duty_sel, ROWS));

    scan_seq #(.SLOT_W(SLOT_W)) u_seq (
        .clk      (clk),
        .rst      (rst),
        .line_en  (line_en),
        .last_idx (last_idx),
        .slot     (slot),
        .at_last  (at_last),
        .ac_pol   (ac_pol)
    );

    line_ctr #(.W(LINE_W)) u_ctr (
        .clk     (clk),
        .rst     (rst),
        .wr      (start_wr),
        .wr_val  (start_val),
        .line_en (line_en),
        .reload  (at_last),
        .cnt     (cnt),
        .start_q (start_q)
    );

    page_decode #(.PAGE_W(PAGE_W), .GFX_PAGES(GFX_PAGES)) u_pdec (
        .page (page_addr),
        .cls  (pcls)
    );

    assign row_addr    = at_last ? ICON_ROW : {1'b0, cnt};
    assign icon_slot   = at_last;
    assign frame_start = (slot == '0);
    assign com_idx     = slot;
    assign page_gfx    = pcls.gfx;
    assign page_icon   = pcls.icon;

    // R6: a line clock in the icon slot starts a new frame
    p_icon_then_start_r6: assert property (@(posedge clk) disable iff (rst)
        (line_en && icon_slot) |=> frame_start);
    // R7: frame start and icon slot never coincide
    p_start_icon_excl_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({frame_start, icon_slot}));
    // R3: first graphic slot fetches the start line
    p_first_row_r3: assert property (@(posedge clk) disable iff (rst)
        (line_en && icon_slot) |=> (row_addr == {1'b0, $past(start_q)}));

endmodule

// File: tb/tb_scroll_line_scan.sv
module tb_scroll_line_scan;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_wr = 1'b0;
    logic [5:0] start_val = '0;
    logic       line_en = 1'b0;
    logic [1:0] duty_sel = 2'b00;
    logic [3:0] page_addr = '0;
    logic [6:0] row_addr;
    logic       frame_start;
    logic       icon_slot;
    logic [6:0] com_idx;
    logic       ac_pol;
    logic       page_gfx;
    logic       page_icon;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    scroll_line_scan dut (
        .clk(clk), .rst(rst), .start_wr(start_wr), .start_val(start_val),
        .line_en(line_en), .duty_sel(duty_sel), .page_addr(page_addr),
        .row_addr(row_addr), .frame_start(frame_start), .icon_slot(icon_slot),
        .com_idx(com_idx), .ac_pol(ac_pol), .page_gfx(page_gfx), .page_icon(page_icon)
    );

    // expected {gfx, icon} for page 0..15
    localparam logic [1:0] PG_EXP [16] = '{
        2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10, 2'b10,
        2'b01, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00, 2'b00
    };

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic run(input int n);
        line_en = 1'b1;
        for (int i = 0; i < n; i++) tick();
        line_en = 1'b0;
    endtask

    task automatic write_start(input logic [5:0] v);
        start_val = v;
        start_wr  = 1'b1;
        tick();
        start_wr  = 1'b0;
    endtask

    task automatic measure(output int n);
        n = 0;
        do begin
            run(1);
            n++;
        end while (!frame_start && n < 200);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int len;
        tick(); tick();
        rst = 1'b0;
        chk("R1 row_addr", row_addr, 0);
        chk("R1 com_idx", com_idx, 0);
        chk("R1 frame_start", frame_start, 1);
        chk("R1 icon_slot", icon_slot, 0);
        chk("R1 ac_pol", ac_pol, 0);

        // R9: page classification table
        for (int p = 0; p < 16; p++) begin
            page_addr = 4'(p);
            #1;
            chk($sformatf("R9 page %0d", p), {page_gfx, page_icon}, PG_EXP[p]);
        end

        // R2: write does not disturb the running frame
        write_start(6'd10);
        chk("R2 row unchanged", row_addr, 0);
        run(31);
        chk("R4 row step", row_addr, 31);
        chk("R11 com_idx", com_idx, 31);
        chk("R7 no start mid frame", frame_start, 0);
        run(1);
        chk("R6 icon row", row_addr, 64);
        chk("R6 icon_slot", icon_slot, 1);
        run(1);
        chk("R3 reload row", row_addr, 10);
        chk("R7 frame_start", frame_start, 1);
        chk("R8 polarity flip", ac_pol, 1);
        run(1);
        chk("R7 start drops", frame_start, 0);
        chk("R4 row after start", row_addr, 11);

        // R4: wrap modulo 64
        write_start(6'd62);
        run(31);
        chk("R6 icon independent of scroll", row_addr, 64);
        run(1);
        chk("R3 reload 62", row_addr, 62);
        chk("R8 polarity back", ac_pol, 0);
        run(2);
        chk("R4 wrap to 0", row_addr, 0);

        // R10: no line clock, nothing moves
        start_val = 6'd20;
        for (int i = 0; i < 5; i++) tick();
        chk("R10 row held", row_addr, 0);
        chk("R10 com held", com_idx, 2);
        chk("R10 pol held", ac_pol, 0);
        write_start(6'd5);
        chk("R2 write mid frame", row_addr, 0);
        start_val = 6'd20;

        // R5: 3/4 duty from slot 2
        duty_sel = 2'b01;
        run(46);
        chk("R5 icon at slot 48", com_idx, 48);
        chk("R6 icon row duty 49", row_addr, 64);
        run(1);
        chk("R2 unwritten value ignored", row_addr, 5);
        measure(len);
        chk("R5 frame length 01", len, 49);
        duty_sel = 2'b10;
        measure(len);
        chk("R5 frame length 10", len, 65);
        duty_sel = 2'b11;
        run(64);
        chk("R6 icon slot duty 65", icon_slot, 1);
        chk("R11 last com", com_idx, 64);
        run(1);
        measure(len);
        chk("R5 frame length 11", len, 65);
        duty_sel = 2'b00;
        measure(len);
        chk("R5 frame length 00", len, 33);

        // R1: reset mid operation
        write_start(6'd40);
        run(3);
        rst = 1'b1;
        tick();
        rst = 1'b0;
        chk("R1 reset row", row_addr, 0);
        chk("R1 reset start", frame_start, 1);
        chk("R1 reset pol", ac_pol, 0);
        run(33);
        chk("R1 start-line cleared", row_addr, 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule